// File: doc/BRIEF.md
# Four-Lane Bypassed Integer Execute Cluster

This block is the integer execute stage of a four-issue VLIW core. It holds four identical single-cycle ALUs. Each ALU has two 32-bit operands. Each operand is fed by a nine-way bypass multiplexer, which picks either the register-file value delivered by decode or one of eight results still held in the execute stage. The eight results come from the four ALUs of this cluster, two memory units and two multiply/divide units. Because read-after-write hazards between these units are resolved only by bypass, the cluster has no stall request at all.

For every operand a selector compares the decode-stage source index with each unit's execute-stage destination index. A unit is a candidate only when its write-back enable is set. When several units match, the unit checked later wins. The ALU results, destinations and enables are registered inside the cluster and become the ALU entries of the bypass network on the next cycle. The memory and multiply/divide entries arrive on plain ports. Register index zero is never bypassed.

Top module: `exec_cluster`

## Requirements
- R1: A synchronous active-high reset clears every lane's result, flag, destination index and write-back enable to zero on the next rising edge.
- R2: Each lane's result and flag appear one clock after the decode inputs are sampled. The lane's destination index and write-back enable are delayed by the same single clock.
- R3: Code 0 adds and code 1 subtracts. For add the flag is the carry out of bit 31. For subtract the flag is 1 exactly when operand A is below operand B unsigned (a borrow).
- R4: Codes 2, 3 and 4 give bitwise AND, OR and XOR, with the flag at 0.
- R5: Codes 5, 6 and 7 shift operand A left, logically right and arithmetically right by operand B bits 4..0, with the flag at 0.
- R6: Code 8 (signed) and code 9 (unsigned) give 1 when A is less than B and 0 otherwise. The flag equals that result.
- R7: Every code from 10 to 63 gives a result of 0 and a flag of 0.
- R8: When no unit qualifies, an operand takes the register-file value from decode.
- R9: A lane operand whose source index equals an ALU lane's registered destination, with that lane's write-back enable set, takes that lane's current result. This applies from any lane to any lane.
- R10: Memory and multiply/divide results on the input ports are bypassed under the same index-and-enable rule.
- R11: Priority rises in the order ALU0, ALU1, ALU2, ALU3, MEM0, MEM1, MUL0, MUL1, so MUL1 wins over every other match.
- R12: A unit whose write-back enable is clear is never selected, even when its index matches.
- R13: A source index of 0 always takes the register-file value.
- R14: The two operands of a lane select their sources independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src_a_idx | input | 24 | Operand A source index per lane (6 bits, lane 0 lowest) |
| dec_src_b_idx | input | 24 | Operand B source index per lane |
| dec_rf_a | input | 128 | Register-file value for operand A per lane |
| dec_rf_b | input | 128 | Register-file value for operand B per lane |
| dec_func | input | 24 | 6-bit function code per lane |
| dec_dst_idx | input | 24 | Destination index per lane |
| dec_wb_en | input | 4 | Write-back enable per lane |
| mem_dst_idx | input | 12 | Execute-stage destination index of each memory unit |
| mem_wb_en | input | 2 | Write-back enable of each memory unit |
| mem_val | input | 64 | Result of each memory unit |
| mul_dst_idx | input | 12 | Execute-stage destination index of each multiply/divide unit |
| mul_wb_en | input | 2 | Write-back enable of each multiply/divide unit |
| mul_val | input | 64 | Result of each multiply/divide unit |
| alu_res | output | 128 | Registered result per lane |
| alu_flag | output | 4 | Registered carry/compare flag per lane |
| alu_dst_idx | output | 24 | Registered destination index per lane |
| alu_wb_en | output | 4 | Registered write-back enable per lane |

## Verification
The bench builds the cluster with its default parameters: four lanes, 32-bit data, 6-bit register indices, two memory and two multiply/divide ports, and index-zero suppression enabled. With these values all nine entries of every bypass multiplexer are reachable, so the tests can stack matches from ALU, memory and multiply/divide units on one index and observe the full priority chain. With suppression enabled the index-zero rule is active and can be exercised against matching units whose enables are set.

// File: rtl/vliw_exec_pkg.sv
package vliw_exec_pkg;

   localparam int FUNC_W = 6;

   typedef enum logic [FUNC_W-1:0] {
      FN_ADD  = 6'd0,
      FN_SUB  = 6'd1,
      FN_AND  = 6'd2,
      FN_OR   = 6'd3,
      FN_XOR  = 6'd4,
      FN_SLL  = 6'd5,
      FN_SRL  = 6'd6,
      FN_SRA  = 6'd7,
      FN_SLT  = 6'd8,
      FN_SLTU = 6'd9
   } alu_fn_e;

   localparam int FN_FIRST_UNUSED = 10;

endpackage

// File: rtl/bypass_select.sv
// Priority selector for one operand: entry 0 is the register file,
// entries 1..NUNIT are execute-stage units; the highest matching entry wins.
module bypass_select #(
   parameter int RIDX_W    = 6,
   parameter int NUNIT     = 8,
   parameter bit ZERO_SKIP = 1'b1,
   localparam int NSRC     = NUNIT + 1,
   localparam int SEL_W    = $clog2(NSRC)
) (
   input  logic [RIDX_W-1:0] src_idx,
   input  logic [RIDX_W-1:0] unit_dst [NUNIT],
   input  logic [NUNIT-1:0]  unit_wb,
   output logic [SEL_W-1:0]  sel
);

   logic [NUNIT-1:0] hit;
   logic             idx_ok;

   generate
      if (ZERO_SKIP) begin : g_skip_zero
         assign idx_ok = (src_idx != '0);
      end else begin : g_any_idx
         assign idx_ok = 1'b1;
      end
   endgenerate

   generate
      for (genvar u = 0; u < NUNIT; u++) begin : g_cmp
         assign hit[u] = idx_ok && unit_wb[u] && (unit_dst[u] == src_idx);
      end
   endgenerate

   always_comb begin
      sel = '0;
      for (int u = 0; u < NUNIT; u++) begin
         if (hit[u]) sel = SEL_W'(u + 1);
      end
   end

endmodule

// File: rtl/bypass_mux.sv
module bypass_mux #(
   parameter int DATA_W = 32,
   parameter int NSRC   = 9,
   localparam int SEL_W = $clog2(NSRC)
) (
   input  logic [DATA_W-1:0] src [NSRC],
   input  logic [SEL_W-1:0]  sel,
   output logic [DATA_W-1:0] dout
);

   always_comb begin
      dout = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (sel == SEL_W'(i)) dout = src[i];
      end
   end

endmodule

// File: rtl/alu_lane.sv
module alu_lane
   import vliw_exec_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int RIDX_W = 6,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [FUNC_W-1:0] func,
   input  logic [RIDX_W-1:0] dst_in,
   input  logic              wb_in,
   output logic [DATA_W-1:0] res_q,
   output logic              flag_q,
   output logic [RIDX_W-1:0] dst_q,
   output logic              wb_q
);

   logic [DATA_W:0]   sum_ext;
   logic [DATA_W:0]   dif_ext;
   logic [SH_W-1:0]   shamt;
   logic              lt_s;
   logic              lt_u;
   logic [DATA_W-1:0] res_d;
   logic              flag_d;

   assign sum_ext = {1'b0, op_a} + {1'b0, op_b};
   assign dif_ext = {1'b0, op_a} - {1'b0, op_b};
   assign shamt   = op_b[SH_W-1:0];
   assign lt_s    = $signed(op_a) < $signed(op_b);
   assign lt_u    = op_a < op_b;

   always_comb begin
      res_d  = '0;
      flag_d = 1'b0;
      case (func)
         FN_ADD:  begin res_d = sum_ext[DATA_W-1:0]; flag_d = sum_ext[DATA_W]; end
         FN_SUB:  begin res_d = dif_ext[DATA_W-1:0]; flag_d = dif_ext[DATA_W]; end
         FN_AND:  res_d = op_a & op_b;
         FN_OR:   res_d = op_a | op_b;
         FN_XOR:  res_d = op_a ^ op_b;
         FN_SLL:  res_d = op_a << shamt;
         FN_SRL:  res_d = op_a >> shamt;
         FN_SRA:  res_d = DATA_W'($signed(op_a) >>> shamt);
         FN_SLT:  begin res_d = DATA_W'(lt_s); flag_d = lt_s; end
         FN_SLTU: begin res_d = DATA_W'(lt_u); flag_d = lt_u; end
         default: begin res_d = '0; flag_d = 1'b0; end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q  <= '0;
         flag_q <= 1'b0;
         dst_q  <= '0;
         wb_q   <= 1'b0;
      end else begin
         res_q  <= res_d;
         flag_q <= flag_d;
         dst_q  <= dst_in;
         wb_q   <= wb_in;
      end
   end

endmodule

// File: rtl/exec_cluster.sv
module exec_cluster
   import vliw_exec_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int DATA_W    = 32,
   parameter int RIDX_W    = 6,
   parameter int MEM_PORTS = 2,
   parameter int MUL_PORTS = 2,
   parameter bit ZERO_SKIP = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [LANES*RIDX_W-1:0]     dec_src_a_idx,
   input  logic [LANES*RIDX_W-1:0]     dec_src_b_idx,
   input  logic [LANES*DATA_W-1:0]     dec_rf_a,
   input  logic [LANES*DATA_W-1:0]     dec_rf_b,
   input  logic [LANES*6-1:0]          dec_func,
   input  logic [LANES*RIDX_W-1:0]     dec_dst_idx,
   input  logic [LANES-1:0]            dec_wb_en,
   input  logic [MEM_PORTS*RIDX_W-1:0] mem_dst_idx,
   input  logic [MEM_PORTS-1:0]        mem_wb_en,
   input  logic [MEM_PORTS*DATA_W-1:0] mem_val,
   input  logic [MUL_PORTS*RIDX_W-1:0] mul_dst_idx,
   input  logic [MUL_PORTS-1:0]        mul_wb_en,
   input  logic [MUL_PORTS*DATA_W-1:0] mul_val,
   output logic [LANES*DATA_W-1:0]     alu_res,
   output logic [LANES-1:0]            alu_flag,
   output logic [LANES*RIDX_W-1:0]     alu_dst_idx,
   output logic [LANES-1:0]            alu_wb_en
);

   localparam int NUNIT = LANES + MEM_PORTS + MUL_PORTS;
   localparam int NSRC  = NUNIT + 1;
   localparam int SEL_W = $clog2(NSRC);
   localparam int MEM_BASE = LANES;
   localparam int MUL_BASE = LANES + MEM_PORTS;

   // elaboration-time parameter checks
   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("exec_cluster: DATA_W must be a power of two of at least 8");
      end
      if (RIDX_W < 1 || LANES < 1) begin : g_bad_shape
         $error("exec_cluster: RIDX_W and LANES must be positive");
      end
      if (MEM_PORTS < 1 || MUL_PORTS < 1) begin : g_bad_ports
         $error("exec_cluster: at least one memory and one multiply port required");
      end
      if (FUNC_W != 6) begin : g_bad_func
         $error("exec_cluster: function code width must be 6");
      end
   endgenerate

   // execute-stage unit table, in ascending bypass priority
   logic [RIDX_W-1:0] unit_dst [NUNIT];
   logic [NUNIT-1:0]  unit_wb;
   logic [DATA_W-1:0] unit_val [NUNIT];

   logic [DATA_W-1:0] lane_res  [LANES];
   logic [RIDX_W-1:0] lane_dstq [LANES];
   logic [LANES-1:0]  lane_wbq;
   logic [LANES-1:0]  lane_flag;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_alu_units
         assign unit_dst[l] = lane_dstq[l];
         assign unit_wb[l]  = lane_wbq[l];
         assign unit_val[l] = lane_res[l];
      end
      for (genvar m = 0; m < MEM_PORTS; m++) begin : g_mem_units
         assign unit_dst[MEM_BASE+m] = mem_dst_idx[m*RIDX_W +: RIDX_W];
         assign unit_wb[MEM_BASE+m]  = mem_wb_en[m];
         assign unit_val[MEM_BASE+m] = mem_val[m*DATA_W +: DATA_W];
      end
      for (genvar k = 0; k < MUL_PORTS; k++) begin : g_mul_units
         assign unit_dst[MUL_BASE+k] = mul_dst_idx[k*RIDX_W +: RIDX_W];
         assign unit_wb[MUL_BASE+k]  = mul_wb_en[k];
         assign unit_val[MUL_BASE+k] = mul_val[k*DATA_W +: DATA_W];
      end
   endgenerate

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [DATA_W-1:0] src_a [NSRC];
         logic [DATA_W-1:0] src_b [NSRC];
         logic [SEL_W-1:0]  sel_a;
         logic [SEL_W-1:0]  sel_b;
         logic [DATA_W-1:0] opnd_a;
         logic [DATA_W-1:0] opnd_b;

         assign src_a[0] = dec_rf_a[l*DATA_W +: DATA_W];
         assign src_b[0] = dec_rf_b[l*DATA_W +: DATA_W];
         for (genvar u = 0; u < NUNIT; u++) begin : g_fan
            assign src_a[u+1] = unit_val[u];
            assign src_b[u+1] = unit_val[u];
         end

         bypass_select #(
            .RIDX_W   (RIDX_W),
            .NUNIT    (NUNIT),
            .ZERO_SKIP(ZERO_SKIP)
         ) u_sel_a (
            .src_idx (dec_src_a_idx[l*RIDX_W +: RIDX_W]),
            .unit_dst(unit_dst),
            .unit_wb (unit_wb),
            .sel     (sel_a)
         );

         bypass_select #(
            .RIDX_W   (RIDX_W),
            .NUNIT    (NUNIT),
            .ZERO_SKIP(ZERO_SKIP)
         ) u_sel_b (
            .src_idx (dec_src_b_idx[l*RIDX_W +: RIDX_W]),
            .unit_dst(unit_dst),
            .unit_wb (unit_wb),
            .sel     (sel_b)
         );

         bypass_mux #(.DATA_W(DATA_W), .NSRC(NSRC)) u_mux_a (
            .src (src_a),
            .sel (sel_a),
            .dout(opnd_a)
         );

         bypass_mux #(.DATA_W(DATA_W), .NSRC(NSRC)) u_mux_b (
            .src (src_b),
            .sel (sel_b),
            .dout(opnd_b)
         );

         alu_lane #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_alu (
            .clk   (clk),
            .rst   (rst),
            .op_a  (opnd_a),
            .op_b  (opnd_b),
            .func  (dec_func[l*FUNC_W +: FUNC_W]),
            .dst_in(dec_dst_idx[l*RIDX_W +: RIDX_W]),
            .wb_in (dec_wb_en[l]),
            .res_q (lane_res[l]),
            .flag_q(lane_flag[l]),
            .dst_q (lane_dstq[l]),
            .wb_q  (lane_wbq[l])
         );

         assign alu_res[l*DATA_W +: DATA_W]     = lane_res[l];
         assign alu_dst_idx[l*RIDX_W +: RIDX_W] = lane_dstq[l];
      end
   endgenerate

   assign alu_flag  = lane_flag;
   assign alu_wb_en = lane_wbq;

endmodule

// File: rtl/exec_cluster_chk.sv
module exec_cluster_chk #(
   parameter int LANES     = 4,
   parameter int DATA_W    = 32,
   parameter int RIDX_W    = 6,
   parameter int MEM_PORTS = 2,
   parameter int MUL_PORTS = 2,
   parameter bit ZERO_SKIP = 1'b1
) (
   input logic                        clk,
   input logic                        rst,
   input logic [LANES*RIDX_W-1:0]     dec_src_a_idx,
   input logic [LANES*RIDX_W-1:0]     dec_src_b_idx,
   input logic [LANES*DATA_W-1:0]     dec_rf_a,
   input logic [LANES*DATA_W-1:0]     dec_rf_b,
   input logic [LANES*6-1:0]          dec_func,
   input logic [LANES*RIDX_W-1:0]     dec_dst_idx,
   input logic [LANES-1:0]            dec_wb_en,
   input logic [MUL_PORTS*RIDX_W-1:0] mul_dst_idx,
   input logic [MUL_PORTS-1:0]        mul_wb_en,
   input logic [MUL_PORTS*DATA_W-1:0] mul_val,
   input logic [LANES*DATA_W-1:0]     alu_res,
   input logic [LANES-1:0]            alu_flag,
   input logic [LANES*RIDX_W-1:0]     alu_dst_idx,
   input logic [LANES-1:0]            alu_wb_en
);

   localparam int TOPK = MUL_PORTS - 1;

   // R1: reset clears all registered lane state
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (alu_res == '0 && alu_flag == '0 && alu_dst_idx == '0 && alu_wb_en == '0));

   // R2: write-back enables trail decode by one cycle
   assert_wb_delay_R2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> alu_wb_en == $past(dec_wb_en));

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
         // R2: destination index trails decode by one cycle
         assert_dst_delay_R2: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> alu_dst_idx[l*RIDX_W +: RIDX_W] == $past(dec_dst_idx[l*RIDX_W +: RIDX_W]));

         // R7: unused codes yield zero result and zero flag
         assert_unused_zero_R7: assert property (@(posedge clk) disable iff (rst)
            (dec_func[l*6 +: 6] >= 6'd10) |=>
               (alu_res[l*DATA_W +: DATA_W] == '0 && !alu_flag[l]));

         // R4, R5: bitwise and shift codes leave the flag clear
         assert_logic_flag_R4: assert property (@(posedge clk) disable iff (rst)
            (dec_func[l*6 +: 6] >= 6'd2 && dec_func[l*6 +: 6] <= 6'd7) |=> !alu_flag[l]);

         // R11: the last multiply/divide port outranks every other match
         assert_top_priority_R11: assert property (@(posedge clk) disable iff (rst)
            (dec_func[l*6 +: 6] == 6'd3 &&
             mul_wb_en[TOPK] && mul_dst_idx[TOPK*RIDX_W +: RIDX_W] != '0 &&
             dec_src_a_idx[l*RIDX_W +: RIDX_W] == mul_dst_idx[TOPK*RIDX_W +: RIDX_W] &&
             dec_src_b_idx[l*RIDX_W +: RIDX_W] == mul_dst_idx[TOPK*RIDX_W +: RIDX_W]) |=>
               alu_res[l*DATA_W +: DATA_W] == $past(mul_val[TOPK*DATA_W +: DATA_W]));

         if (ZERO_SKIP) begin : g_zero_chk
            // R13: index zero always reads the register-file value
            assert_zero_idx_R13: assert property (@(posedge clk) disable iff (rst)
               (dec_func[l*6 +: 6] == 6'd3 &&
                dec_src_a_idx[l*RIDX_W +: RIDX_W] == '0 &&
                dec_src_b_idx[l*RIDX_W +: RIDX_W] == '0) |=>
                  alu_res[l*DATA_W +: DATA_W] ==
                     $past(dec_rf_a[l*DATA_W +: DATA_W] | dec_rf_b[l*DATA_W +: DATA_W]));
         end
      end
   endgenerate

endmodule

bind exec_cluster exec_cluster_chk #(
   .LANES    (LANES),
   .DATA_W   (DATA_W),
   .RIDX_W   (RIDX_W),
   .MEM_PORTS(MEM_PORTS),
   .MUL_PORTS(MUL_PORTS),
   .ZERO_SKIP(ZERO_SKIP)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .dec_src_a_idx(dec_src_a_idx),
   .dec_src_b_idx(dec_src_b_idx),
   .dec_rf_a     (dec_rf_a),
   .dec_rf_b     (dec_rf_b),
   .dec_func     (dec_func),
   .dec_dst_idx  (dec_dst_idx),
   .dec_wb_en    (dec_wb_en),
   .mul_dst_idx  (mul_dst_idx),
   .mul_wb_en    (mul_wb_en),
   .mul_val      (mul_val),
   .alu_res      (alu_res),
   .alu_flag     (alu_flag),
   .alu_dst_idx  (alu_dst_idx),
   .alu_wb_en    (alu_wb_en)
);

// File: tb/exec_cluster_bench.sv
`timescale 1ns/1ps
module exec_cluster_bench;

   localparam int L  = 4;
   localparam int W  = 32;
   localparam int RW = 6;

   logic          clk = 1'b0;
   logic          rst;
   logic [L*RW-1:0] dec_src_a_idx, dec_src_b_idx, dec_dst_idx;
   logic [L*W-1:0]  dec_rf_a, dec_rf_b;
   logic [L*6-1:0]  dec_func;
   logic [L-1:0]    dec_wb_en;
   logic [2*RW-1:0] mem_dst_idx, mul_dst_idx;
   logic [1:0]      mem_wb_en, mul_wb_en;
   logic [2*W-1:0]  mem_val, mul_val;
   logic [L*W-1:0]  alu_res;
   logic [L-1:0]    alu_flag;
   logic [L*RW-1:0] alu_dst_idx;
   logic [L-1:0]    alu_wb_en;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   exec_cluster u_exec_cluster (
      .clk(clk), .rst(rst),
      .dec_src_a_idx(dec_src_a_idx), .dec_src_b_idx(dec_src_b_idx),
      .dec_rf_a(dec_rf_a), .dec_rf_b(dec_rf_b),
      .dec_func(dec_func), .dec_dst_idx(dec_dst_idx), .dec_wb_en(dec_wb_en),
      .mem_dst_idx(mem_dst_idx), .mem_wb_en(mem_wb_en), .mem_val(mem_val),
      .mul_dst_idx(mul_dst_idx), .mul_wb_en(mul_wb_en), .mul_val(mul_val),
      .alu_res(alu_res), .alu_flag(alu_flag),
      .alu_dst_idx(alu_dst_idx), .alu_wb_en(alu_wb_en)
   );

   // expected lane behaviour from the requirements: {flag, result}
   function automatic logic [W:0] ref_alu(logic [5:0] f, logic [W-1:0] a, logic [W-1:0] b);
      logic [W:0] t;
      case (f)
         6'd0: t = {1'b0, a} + {1'b0, b};
         6'd1: t = {(a < b), a - b};
         6'd2: t = {1'b0, a & b};
         6'd3: t = {1'b0, a | b};
         6'd4: t = {1'b0, a ^ b};
         6'd5: t = {1'b0, a << b[4:0]};
         6'd6: t = {1'b0, a >> b[4:0]};
         6'd7: t = {1'b0, W'($signed(a) >>> b[4:0])};
         6'd8: t = {($signed(a) < $signed(b)), 31'd0, ($signed(a) < $signed(b))};
         6'd9: t = {(a < b), 31'd0, (a < b)};
         default: t = '0;
      endcase
      return t;
   endfunction

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_all();
      dec_src_a_idx = '0; dec_src_b_idx = '0; dec_dst_idx = '0;
      dec_rf_a = '0; dec_rf_b = '0; dec_func = '0; dec_wb_en = '0;
      mem_dst_idx = '0; mem_wb_en = '0; mem_val = '0;
      mul_dst_idx = '0; mul_wb_en = '0; mul_val = '0;
   endtask

   task automatic lane(int l, logic [5:0] f, logic [5:0] ia, logic [5:0] ib,
                       logic [W-1:0] ra, logic [W-1:0] rb, logic [5:0] d, logic wb);
      dec_func[l*6 +: 6]        = f;
      dec_src_a_idx[l*RW +: RW] = ia;
      dec_src_b_idx[l*RW +: RW] = ib;
      dec_rf_a[l*W +: W]        = ra;
      dec_rf_b[l*W +: W]        = rb;
      dec_dst_idx[l*RW +: RW]   = d;
      dec_wb_en[l]              = wb;
   endtask

   task automatic unit(bit is_mul, int p, logic [5:0] d, logic wb, logic [W-1:0] v);
      if (is_mul) begin
         mul_dst_idx[p*RW +: RW] = d; mul_wb_en[p] = wb; mul_val[p*W +: W] = v;
      end else begin
         mem_dst_idx[p*RW +: RW] = d; mem_wb_en[p] = wb; mem_val[p*W +: W] = v;
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [W-1:0] res_of(int l);
      return alu_res[l*W +: W];
   endfunction

   // lane ops checked against the reference with no bypass active
   task automatic run_direct(string req, logic [5:0] f [L], logic [W-1:0] a [L], logic [W-1:0] b [L]);
      idle_all();
      for (int l = 0; l < L; l++) lane(l, f[l], 6'd40 + 6'(l), 6'd50 + 6'(l), a[l], b[l], 6'd0, 1'b0);
      step();
      for (int l = 0; l < L; l++) begin
         logic [W:0] e;
         e = ref_alu(f[l], a[l], b[l]);
         chk(req, res_of(l), e[W-1:0]);
         chk(req, W'(alu_flag[l]), W'(e[W]));
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      idle_all();
      lane(0, 6'd0, 6'd1, 6'd2, 32'h5, 32'h6, 6'd9, 1'b1);
      step(); step();
      chk("R1 result after reset", alu_res[W-1:0], '0);
      chk("R1 wb after reset", W'(alu_wb_en), '0);
      chk("R1 dst after reset", W'(alu_dst_idx), '0);
      rst = 1'b0;
      idle_all();
      step();
   endtask

   task automatic t_arith();
      logic [5:0] f [L] = '{6'd0, 6'd1, 6'd0, 6'd1};
      logic [W-1:0] a [L] = '{32'hFFFF_FFFF, 32'd3, 32'd10, 32'd9};
      logic [W-1:0] b [L] = '{32'd1, 32'd5, 32'd20, 32'd4};
      run_direct("R3 add/sub", f, a, b);
   endtask

   task automatic t_pipe();
      idle_all();
      lane(1, 6'd3, 6'd0, 6'd0, 32'h1, 32'h0, 6'd17, 1'b1);
      lane(2, 6'd3, 6'd0, 6'd0, 32'h1, 32'h0, 6'd33, 1'b0);
      step();
      chk("R2 dst lane1", W'(alu_dst_idx[1*RW +: RW]), 32'd17);
      chk("R2 dst lane2", W'(alu_dst_idx[2*RW +: RW]), 32'd33);
      chk("R2 wb", W'(alu_wb_en), 32'b0010);
      idle_all();
      step();
      chk("R2 wb drops after one cycle", W'(alu_wb_en), '0);
   endtask

   task automatic t_logic();
      logic [5:0] f1 [L] = '{6'd2, 6'd3, 6'd4, 6'd5};
      logic [W-1:0] a1 [L] = '{32'hF0F0_1234, 32'h0F00_0001, 32'hFFFF_0000, 32'h8000_0001};
      logic [W-1:0] b1 [L] = '{32'h0FF0_FF00, 32'h00F0_0010, 32'h0F0F_0F0F, 32'd4};
      logic [5:0] f2 [L] = '{6'd6, 6'd7, 6'd5, 6'd7};
      logic [W-1:0] a2 [L] = '{32'h8000_0000, 32'h8000_0000, 32'h0000_0003, 32'h7FFF_FFFF};
      logic [W-1:0] b2 [L] = '{32'd31, 32'd4, 32'd33, 32'd31};
      run_direct("R4 bitwise", f1, a1, b1);
      run_direct("R5 shifts", f2, a2, b2);
   endtask

   task automatic t_cmp();
      logic [5:0] f [L] = '{6'd8, 6'd9, 6'd8, 6'd9};
      logic [W-1:0] a [L] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd5, 32'd1};
      logic [W-1:0] b [L] = '{32'd1, 32'd1, 32'd5, 32'd2};
      run_direct("R6 compare", f, a, b);
   endtask

   task automatic t_unused();
      logic [5:0] f [L] = '{6'd10, 6'd31, 6'd63, 6'd12};
      logic [W-1:0] a [L] = '{32'hFFFF_FFFF, 32'h1234, 32'hFFFF_FFFF, 32'h7};
      logic [W-1:0] b [L] = '{32'hFFFF_FFFF, 32'h1, 32'd1, 32'h9};
      run_direct("R7 unused codes", f, a, b);
   endtask

   task automatic t_no_match();
      idle_all();
      unit(1'b0, 0, 6'd5, 1'b0, 32'hDEAD);
      lane(0, 6'd3, 6'd5, 6'd6, 32'h0000_1200, 32'h0000_0034, 6'd0, 1'b0);
      step();
      chk("R8 register-file values", res_of(0), 32'h0000_1234);
   endtask

   task automatic t_alu_fwd();
      idle_all();
      lane(2, 6'd0, 6'd40, 6'd41, 32'd100, 32'd23, 6'd7, 1'b1);
      lane(3, 6'd3, 6'd40, 6'd41, 32'hF0, 32'h0F, 6'd8, 1'b1);
      step();
      idle_all();
      lane(0, 6'd0, 6'd7, 6'd8, 32'd999, 32'd0, 6'd0, 1'b0);
      lane(1, 6'd1, 6'd8, 6'd2, 32'd0, 32'd1, 6'd0, 1'b0);
      step();
      chk("R9 lane2+lane3 into lane0", res_of(0), 32'd378);
      chk("R9 lane3 into lane1 (R14 b from rf)", res_of(1), 32'd254);
   endtask

   task automatic t_mem_mul();
      idle_all();
      unit(1'b0, 0, 6'd10, 1'b1, 32'h0000_AAAA);
      unit(1'b1, 1, 6'd11, 1'b1, 32'h0000_5555);
      lane(0, 6'd3, 6'd10, 6'd11, 32'h0, 32'h0, 6'd0, 1'b0);
      lane(1, 6'd2, 6'd10, 6'd12, 32'h0, 32'h0000_FF00, 6'd0, 1'b0);
      step();
      chk("R10 mem0|mul1 (R14)", res_of(0), 32'h0000_FFFF);
      chk("R10 mem0&rf", res_of(1), 32'h0000_AA00);
   endtask

   task automatic t_priority();
      idle_all();
      lane(1, 6'd3, 6'd40, 6'd0, 32'h11, 32'h0, 6'd20, 1'b1);
      lane(3, 6'd3, 6'd40, 6'd0, 32'h33, 32'h0, 6'd20, 1'b1);
      step();
      idle_all();
      unit(1'b0, 0, 6'd21, 1'b1, 32'h77);
      unit(1'b0, 1, 6'd21, 1'b1, 32'h99);
      unit(1'b1, 0, 6'd21, 1'b1, 32'h88);
      lane(0, 6'd3, 6'd20, 6'd0, 32'hFFFF, 32'h0, 6'd0, 1'b0);
      lane(1, 6'd3, 6'd21, 6'd0, 32'hFFFF, 32'h0, 6'd0, 1'b0);
      lane(3, 6'd3, 6'd40, 6'd0, 32'h1, 32'h0, 6'd30, 1'b1);
      step();
      chk("R11 alu3 over alu1", res_of(0), 32'h33);
      chk("R11 mul0 over mem0/mem1", res_of(1), 32'h88);
      idle_all();
      unit(1'b0, 0, 6'd30, 1'b1, 32'h44);
      unit(1'b0, 1, 6'd30, 1'b1, 32'h55);
      unit(1'b1, 0, 6'd30, 1'b1, 32'hDD);
      unit(1'b1, 1, 6'd30, 1'b1, 32'hEE);
      lane(0, 6'd3, 6'd30, 6'd0, 32'hFFFF, 32'h0, 6'd0, 1'b0);
      step();
      chk("R11 mul1 over all", res_of(0), 32'hEE);
      idle_all();
      unit(1'b0, 0, 6'd31, 1'b1, 32'h44);
      unit(1'b0, 1, 6'd31, 1'b1, 32'h55);
      lane(2, 6'd3, 6'd31, 6'd0, 32'hFFFF, 32'h0, 6'd0, 1'b0);
      step();
      chk("R11 mem1 over mem0", res_of(2), 32'h55);
   endtask

   task automatic t_wb_off();
      idle_all();
      lane(2, 6'd3, 6'd40, 6'd0, 32'hBAD, 32'h0, 6'd25, 1'b0);
      step();
      idle_all();
      unit(1'b0, 0, 6'd25, 1'b0, 32'hBAD0);
      unit(1'b0, 1, 6'd25, 1'b0, 32'hBAD1);
      unit(1'b1, 0, 6'd25, 1'b0, 32'hBAD2);
      unit(1'b1, 1, 6'd25, 1'b0, 32'hBAD3);
      lane(0, 6'd3, 6'd25, 6'd0, 32'h1234, 32'h0, 6'd0, 1'b0);
      step();
      chk("R12 disabled units ignored", res_of(0), 32'h1234);
   endtask

   task automatic t_zero();
      idle_all();
      lane(0, 6'd3, 6'd40, 6'd0, 32'hABC, 32'h0, 6'd0, 1'b1);
      step();
      idle_all();
      unit(1'b0, 0, 6'd0, 1'b1, 32'hDEAD);
      unit(1'b1, 1, 6'd0, 1'b1, 32'hBEEF);
      lane(1, 6'd3, 6'd0, 6'd0, 32'h42, 32'h100, 6'd0, 1'b0);
      step();
      chk("R13 index zero reads rf", res_of(1), 32'h142);
   endtask

   task automatic t_midreset();
      idle_all();
      lane(0, 6'd0, 6'd40, 6'd41, 32'd7, 32'd8, 6'd3, 1'b1);
      step();
      chk("R3 pre-reset add", res_of(0), 32'd15);
      rst = 1'b1;
      step();
      chk("R1 mid-run reset result", res_of(0), '0);
      chk("R1 mid-run reset dst", W'(alu_dst_idx[RW-1:0]), '0);
      rst = 1'b0;
      idle_all();
      step();
   endtask

   initial begin
      t_reset();
      t_arith();
      t_pipe();
      t_logic();
      t_cmp();
      t_unused();
      t_no_match();
      t_alu_fwd();
      t_mem_mul();
      t_priority();
      t_wb_off();
      t_zero();
      t_midreset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule